// File: doc/BRIEF.md
# Windowed Register File Controller

This block sits between the execution unit and the on-chip register RAM. Each register-direct access carries an 8-bit byte address, a size (byte, word or doubleword) and, for writes, data. The low 256-byte address space is the lower file: its bottom 24 bytes are reserved for the core special-function registers and the stack pointer, and those accesses are sent to a separate SFR port, not to RAM. The remaining lower bytes are general-purpose RAM. A larger upper file holds only general-purpose RAM.

The upper file cannot be addressed directly. Software programs a window-select register with an enable, a window size (32, 64 or 128 bytes) and a block index. While the window is active, the top bytes of the lower address space (the window always ends at 0xFF) are redirected to the chosen block of the upper file. Lower-file bytes under the window are hidden but keep their contents. Reads answer one cycle after the request. Data is little-endian: byte k of the data bus belongs to address `addr + k`.

Top module: `regfile_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rvalid`, `err` and `sfr_req` are 0 and the window is disabled, so addresses 0xE0 to 0xFF reach the lower file.
- R2: A legal access whose address is below 24 asserts `sfr_req` in the request cycle with `sfr_we`, `sfr_size`, `sfr_addr` (the low 5 address bits) and `sfr_wdata` copied from the request. For a read, `sfr_rdata` sampled in that cycle is returned on `rdata` in the next cycle, and no RAM is touched.
- R3: Legal accesses at addresses 24 to 255 outside an active window read or write the lower file. Read data appears with `rvalid` one cycle after the request; unused high `rdata` bits are 0.
- R4: A write changes only the bytes it addresses: 1 byte, 2 bytes or 4 bytes starting at `addr`.
- R5: The `size` code is 0 for byte, 1 for word and 2 for doubleword. Code 3 is illegal and is treated like a misaligned access.
- R6: A word at an odd address, a doubleword at an address that is not a multiple of 4, or an illegal size raises `err` for one cycle after the request. It gives no `rvalid`, writes no RAM and does not assert `sfr_req`.
- R7: A cycle with `win_we` high loads `win_en`, `win_size` (0 = 32 bytes, 1 = 64, 2 = 128, 3 = window off) and `win_blk`. The new setting applies from the next cycle.
- R8: While the window is active with size S, an address `a` at or above 256−S reaches upper byte `(win_blk·S + a − (256−S)) mod UPPER_BYTES`. In effect, the block index wraps at the number of blocks.
- R9: Lower-file bytes covered by an active window keep their contents and are visible again once the window is disabled or moved away.
- R10: The upper file is never accessed while the window is inactive, and the window never covers addresses below 128, so the SFR region is never overlaid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_we | input | 1 | Load the window-select register |
| win_en | input | 1 | Window enable value to load |
| win_size | input | 2 | Window size code to load |
| win_blk | input | BLK_W | Upper-file block index to load |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Access size code |
| addr | input | 8 | Register-direct byte address |
| wdata | input | 32 | Write data, little-endian |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid (cycle after request) |
| err | output | 1 | Misaligned or illegal access (cycle after request) |
| sfr_req | output | 1 | Access is routed to the SFR port |
| sfr_we | output | 1 | SFR write strobe qualifier |
| sfr_size | output | 2 | SFR access size code |
| sfr_addr | output | 5 | SFR byte address |
| sfr_wdata | output | 32 | SFR write data |
| sfr_rdata | input | 32 | SFR read data, valid in the request cycle |

## Verification
The bench exercises window boundaries for all three sizes, block indices beyond the block count, and the size code that turns the window off. A design with a wrong base or wrap would return data from the wrong upper block, and a wrong bound would leak window accesses into the lower file. The bench checks that bytes hidden by the window survive writes made through it; a design that also wrote the lower file would return corrupted values after the window is disabled. Misaligned and illegal accesses, including ones aimed at the SFR range, are checked for complete silence. Partial writes are read back as doublewords to catch byte enables that spill into neighbouring bytes.

// File: rtl/rfw_pkg.sv
// Package: shared types and constants for the windowed register file controller.
// Assumes an 8-bit register-direct address space and a 32-bit data path.
package rfw_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int LANES       = DATA_W / 8;
    localparam int LOWER_BYTES = 256;
    localparam int SFR_BYTES   = 24;
    localparam int SFR_AW      = $clog2(SFR_BYTES);
    localparam int WIN_MIN_LG  = 5;   // smallest window is 32 bytes

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_LOW  = 2'd2,
        TGT_UP   = 2'd3
    } target_e;
endpackage

// File: rtl/rfw_wincfg.sv
// Window-select register. Holds enable, size code and block index, and
// derives the lower bound of the window and the upper-file base address.
// Assumes UAW >= 8 and an upper file that is a power of two in size.
module rfw_wincfg
    import rfw_pkg::*;
#(
    parameter int BLK_W = 5,
    parameter int UAW   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_we,
    input  logic             win_en,
    input  logic [1:0]       win_size,
    input  logic [BLK_W-1:0] win_blk,
    output logic             win_active,
    output logic [ADDR_W-1:0] win_lo_bound,
    output logic [UAW-1:0]   up_base
);
    logic             en_q;
    logic [1:0]       size_q;
    logic [BLK_W-1:0] blk_q;
    logic [8:0]       span;

    // Load the configuration; reset leaves the window off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            size_q <= 2'd0;
            blk_q  <= '0;
        end else if (win_we) begin
            en_q   <= win_en;
            size_q <= win_size;
            blk_q  <= win_blk;
        end
    end

    // Derive bound and base; size code 3 disables the window.
    always_comb begin
        span         = 9'd32 << size_q;
        win_active   = en_q && (size_q != 2'd3);
        win_lo_bound = 8'(9'd256 - span);
        up_base      = UAW'(blk_q) << (WIN_MIN_LG + 32'(size_q));
    end

    // R10: an active window starts at 128 or higher, clear of the SFR bytes
    p_window_clear_of_sfr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_active |-> (win_lo_bound >= 8'd128));
endmodule

// File: rtl/rfw_decode.sv
// Access decoder: checks alignment and size, picks the target (SFR port,
// lower file or upper file) and forms the upper-file address and byte enables.
// Purely combinational; assumes window bounds are multiples of 32.
module rfw_decode
    import rfw_pkg::*;
#(
    parameter int UAW = 10
) (
    input  logic              req,
    input  acc_size_e         size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_active,
    input  logic [ADDR_W-1:0] win_lo_bound,
    input  logic [UAW-1:0]    up_base,
    output target_e           tgt,
    output logic              misaligned,
    output logic [UAW-1:0]    up_addr,
    output logic [LANES-1:0]  be
);
    logic              in_sfr;
    logic              in_win;
    logic [ADDR_W-1:0] win_off;

    // Alignment and size legality.
    always_comb begin
        unique case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_WORD:  misaligned = addr[0];
            SZ_DWORD: misaligned = |addr[1:0];
            default:  misaligned = 1'b1;
        endcase
    end

    // Byte enables by access size.
    always_comb begin
        unique case (size)
            SZ_BYTE:  be = 4'b0001;
            SZ_WORD:  be = 4'b0011;
            SZ_DWORD: be = 4'b1111;
            default:  be = 4'b0000;
        endcase
    end

    // Region decode and window translation.
    always_comb begin
        in_sfr  = addr < ADDR_W'(SFR_BYTES);
        in_win  = win_active && (addr >= win_lo_bound);
        win_off = addr - win_lo_bound;
        up_addr = up_base + UAW'(win_off);
        if (!req || misaligned) tgt = TGT_NONE;
        else if (in_sfr)        tgt = TGT_SFR;
        else if (in_win)        tgt = TGT_UP;
        else                    tgt = TGT_LOW;
    end
endmodule

// File: rtl/rfw_bank.sv
// Byte-addressed RAM bank with a 32-bit little-endian port. Writes update
// only enabled lanes; reads are registered (data valid the next cycle).
// Assumes accesses are aligned so lanes never wrap past the top of the bank.
module rfw_bank
    import rfw_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [7:0] mem [DEPTH];

    // Write enabled lanes.
    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int i = 0; i < LANES; i++) begin
                if (be[i]) mem[addr + AW'(i)] <= wdata[8*i +: 8];
            end
        end
    end

    // Registered read of all lanes; the top level masks unused ones.
    always_ff @(posedge clk) begin
        if (en && !we) begin
            for (int i = 0; i < LANES; i++) begin
                rdata[8*i +: 8] <= mem[addr + AW'(i)];
            end
        end
    end

    // R4: byte enables are contiguous from lane 0 on any bank access
    p_contiguous_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (be == 4'b0001 || be == 4'b0011 || be == 4'b1111));
endmodule

// File: rtl/regfile_window_ctrl.sv
// Windowed register file controller (top). Decodes register-direct accesses,
// diverts the bottom SFR bytes to the SFR port, redirects the window region to
// the upper file and returns read data one cycle after the request.
// Assumes UPPER_BYTES is a power of two between 256 and a few thousand.
module regfile_window_ctrl
    import rfw_pkg::*;
#(
    parameter int UPPER_BYTES = 1024,
    localparam int UAW   = $clog2(UPPER_BYTES),
    localparam int BLK_W = $clog2(UPPER_BYTES / 32)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_we,
    input  logic              win_en,
    input  logic [1:0]        win_size,
    input  logic [BLK_W-1:0]  win_blk,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              err,
    output logic              sfr_req,
    output logic              sfr_we,
    output logic [1:0]        sfr_size,
    output logic [4:0]        sfr_addr,
    output logic [31:0]       sfr_wdata,
    input  logic [31:0]       sfr_rdata
);
    acc_size_e         size_e;
    logic              win_active;
    logic [ADDR_W-1:0] win_lo_bound;
    logic [UAW-1:0]    up_base;
    target_e           tgt;
    logic              misaligned;
    logic [UAW-1:0]    up_addr;
    logic [LANES-1:0]  be;
    logic              lo_en, up_en;
    logic [DATA_W-1:0] lo_q, up_q;
    target_e           tgt_q;
    acc_size_e         size_q;
    logic [DATA_W-1:0] sfr_q;
    logic [DATA_W-1:0] raw;

    assign size_e = acc_size_e'(size);

    rfw_wincfg #(.BLK_W(BLK_W), .UAW(UAW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_en(win_en),
        .win_size(win_size), .win_blk(win_blk), .win_active(win_active),
        .win_lo_bound(win_lo_bound), .up_base(up_base)
    );

    rfw_decode #(.UAW(UAW)) u_dec (
        .req(req), .size(size_e), .addr(addr), .win_active(win_active),
        .win_lo_bound(win_lo_bound), .up_base(up_base), .tgt(tgt),
        .misaligned(misaligned), .up_addr(up_addr), .be(be)
    );

    assign lo_en = (tgt == TGT_LOW);
    assign up_en = (tgt == TGT_UP);

    rfw_bank #(.DEPTH(LOWER_BYTES)) u_lower (
        .clk(clk), .rst_n(rst_n), .en(lo_en), .we(we), .addr(addr),
        .be(be), .wdata(wdata), .rdata(lo_q)
    );

    rfw_bank #(.DEPTH(UPPER_BYTES)) u_upper (
        .clk(clk), .rst_n(rst_n), .en(up_en), .we(we), .addr(up_addr),
        .be(be), .wdata(wdata), .rdata(up_q)
    );

    // SFR port is a direct view of the request when it targets the SFR bytes.
    always_comb begin
        sfr_req   = (tgt == TGT_SFR);
        sfr_we    = we;
        sfr_size  = size;
        sfr_addr  = addr[SFR_AW-1:0];
        sfr_wdata = wdata;
    end

    // Response state: target, size, handshake flags and captured SFR data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= TGT_NONE;
            size_q <= SZ_BYTE;
            rvalid <= 1'b0;
            err    <= 1'b0;
            sfr_q  <= '0;
        end else begin
            tgt_q  <= we ? TGT_NONE : tgt;
            size_q <= size_e;
            rvalid <= req && !we && !misaligned;
            err    <= req && misaligned;
            if (tgt == TGT_SFR && !we) sfr_q <= sfr_rdata;
        end
    end

    // Select the source of the returned data and clear lanes beyond the size.
    always_comb begin
        unique case (tgt_q)
            TGT_SFR: raw = sfr_q;
            TGT_LOW: raw = lo_q;
            TGT_UP:  raw = up_q;
            default: raw = '0;
        endcase
        unique case (size_q)
            SZ_BYTE:  rdata = {24'd0, raw[7:0]};
            SZ_WORD:  rdata = {16'd0, raw[15:0]};
            default:  rdata = raw;
        endcase
    end

    // R6: an error response never comes with read data
    p_err_without_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rvalid);
    // R6: a misaligned word touches no RAM and no SFR
    p_misaligned_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && size == 2'd1 && addr[0]) |-> (!sfr_req && !lo_en && !up_en));
    // R3: a byte read is always answered on the next cycle
    p_byte_read_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && size == 2'd0) |=> rvalid);
    // R2: the SFR port is only used for the reserved bottom bytes
    p_sfr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_req |-> (addr < 8'd24));
    // R10: the upper file is reached only through an active window
    p_upper_needs_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |-> (win_active && addr >= 8'd128));
endmodule

// File: tb/tb_regfile_window_ctrl.sv
// Bench: behavioural reference model (byte arrays, integers) compared every clock.
module tb_regfile_window_ctrl;
    localparam int UB = 1024;
    localparam int BW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_we = 0, win_en = 0;
    logic [1:0] win_size = 0;
    logic [BW-1:0] win_blk = 0;
    logic req = 0, we = 0;
    logic [1:0] size = 0;
    logic [7:0] addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata, sfr_wdata, sfr_rdata;
    logic rvalid, err, sfr_req, sfr_we;
    logic [1:0] sfr_size;
    logic [4:0] sfr_addr;

    always #4 clk = ~clk;

    regfile_window_ctrl #(.UPPER_BYTES(UB)) dut (
        .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_en(win_en),
        .win_size(win_size), .win_blk(win_blk), .req(req), .we(we),
        .size(size), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rvalid(rvalid), .err(err), .sfr_req(sfr_req), .sfr_we(sfr_we),
        .sfr_size(sfr_size), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    function automatic logic [31:0] sfr_pat(logic [4:0] a);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = (8'(a) + 8'(i)) ^ 8'h5A;
        return r;
    endfunction
    assign sfr_rdata = sfr_pat(sfr_addr);

    logic [7:0] lo_m [256];
    logic [7:0] up_m [UB];
    bit m_en = 0;
    int m_sz = 0, m_blk = 0;

    bit nxt_rvalid = 0, nxt_err = 0, exp_rvalid = 0, exp_err = 0;
    logic [31:0] nxt_rdata = 0, exp_rdata = 0;
    string nxt_tag = "idle", exp_tag = "idle";
    int checks = 0, errors = 0;
    bit monitor_on = 0, done = 0;

    function automatic int win_idx(int a);
        int s, base;
        if (!m_en || m_sz == 3) return -1;
        s = 32 << m_sz;
        base = 256 - s;
        if (a < base) return -1;
        return (m_blk * s + a - base) % UB;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_rvalid <= 0; exp_err <= 0; exp_rdata <= 0; exp_tag <= "R1";
        end else begin
            exp_rvalid <= nxt_rvalid; exp_err <= nxt_err;
            exp_rdata <= nxt_rdata; exp_tag <= nxt_tag;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (monitor_on && !done) begin
            checks++;
            if (rvalid !== exp_rvalid || err !== exp_err ||
                (exp_rvalid && rdata !== exp_rdata)) begin
                errors++;
                $display("FAIL %s: rvalid/err/rdata actual %b/%b/%h expected %b/%b/%h",
                         exp_tag, rvalid, err, rdata, exp_rvalid, exp_err, exp_rdata);
            end
        end
    end

    task automatic set_win(bit en, int sz, int blk);
        @(negedge clk);
        win_we = 1; win_en = en; win_size = 2'(sz); win_blk = BW'(blk);
        m_en = en; m_sz = sz; m_blk = blk % (1 << BW);
        nxt_tag = "R7";
        @(negedge clk);
        win_we = 0;
    endtask

    task automatic op(string tag, bit w, int sz, int a, logic [31:0] d);
        bit mis, sfr_hit;
        int nb, ab, ix;
        logic [31:0] rd;
        string t;
        @(negedge clk);
        req = 1; we = w; size = 2'(sz); addr = 8'(a); wdata = d;
        nb = (sz == 3) ? 0 : (1 << sz);
        mis = (sz == 3) || ((a % nb) != 0);
        sfr_hit = !mis && a < 24;
        ix = win_idx(a);
        t = tag;
        if (t == "") t = mis ? "R6" : (a < 24) ? "R2" : (ix >= 0) ? "R8" : "R3";
        #1;
        checks++;
        if (sfr_req !== sfr_hit || (sfr_hit && (sfr_we !== w || sfr_addr !== 5'(a) ||
            sfr_size !== 2'(sz) || sfr_wdata !== d))) begin
            errors++;
            $display("FAIL %s: sfr_req/we/addr actual %b/%b/%h expected %b/%b/%h",
                     t, sfr_req, sfr_we, sfr_addr, sfr_hit, w, 5'(a));
        end
        rd = 0;
        if (!mis) begin
            for (int i = 0; i < nb; i++) begin
                ab = a + i;
                ix = win_idx(ab);
                if (ab < 24) begin
                    if (!w) rd[8*i +: 8] = sfr_pat(5'(a))[8*i +: 8];
                end else if (ix >= 0) begin
                    if (w) up_m[ix] = d[8*i +: 8]; else rd[8*i +: 8] = up_m[ix];
                end else begin
                    if (w) lo_m[ab] = d[8*i +: 8]; else rd[8*i +: 8] = lo_m[ab];
                end
            end
        end
        nxt_rvalid = !mis && !w; nxt_err = mis; nxt_rdata = rd; nxt_tag = t;
        @(negedge clk);
        req = 0;
        nxt_rvalid = 0; nxt_err = 0; nxt_rdata = 0; nxt_tag = "idle";
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run actual still busy expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) lo_m[i] = 0;
        for (int i = 0; i < UB; i++) up_m[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (rvalid !== 0 || err !== 0 || sfr_req !== 0) begin
            errors++;
            $display("FAIL R1: rvalid/err/sfr_req actual %b/%b/%b expected 0/0/0",
                     rvalid, err, sfr_req);
        end
        monitor_on = 1;
        // R3: fill the lower file through doubleword writes
        for (int a = 24; a < 256; a += 4) op("R3", 1, 2, a, $urandom);
        // R1: window is off after reset, so 0xF0 reads the lower file
        op("R1", 0, 2, 8'hF0, 0);
        // R8: fill every upper block through a 128-byte window
        for (int b = 0; b < 8; b++) begin
            set_win(1, 2, b);
            for (int a = 128; a < 256; a += 4) op("R8", 1, 2, a, $urandom);
        end
        // R7: new window setting applies to the very next access
        set_win(1, 0, 3);
        op("R7", 0, 2, 8'hE0, 0);
        op("R7", 0, 2, 8'hDC, 0);
        // R8: block index wraps at the number of blocks (13 -> block 5 of 8)
        set_win(1, 2, 13);
        op("R8", 0, 2, 8'h80, 0);
        set_win(1, 1, 31);
        op("R8", 0, 2, 8'hC0, 0);
        op("R8", 0, 2, 8'hBC, 0);
        // R7: size code 3 turns the window off
        set_win(1, 3, 2);
        op("R7", 0, 2, 8'hF0, 0);
        // R9: hidden lower bytes survive writes through the window
        set_win(0, 0, 0);
        op("R9", 1, 2, 8'hF0, 32'h1122_3344);
        set_win(1, 0, 3);
        op("R9", 1, 2, 8'hF0, 32'hAABB_CCDD);
        op("R9", 0, 2, 8'hF0, 0);
        set_win(0, 0, 3);
        op("R9", 0, 2, 8'hF0, 0);
        // R10: with the window off the upper file is unreachable
        op("R10", 0, 2, 8'hFC, 0);
        // R2: SFR routing for writes and reads of each size
        op("R2", 1, 1, 8'h10, 32'h0000_BEEF);
        op("R2", 0, 2, 8'h14, 0);
        op("R2", 0, 1, 8'h06, 0);
        op("R2", 0, 0, 8'h17, 0);
        // R4: partial writes touch only their bytes
        op("R4", 1, 0, 8'h45, 32'hFFFF_FF77);
        op("R4", 1, 1, 8'h4A, 32'hFFFF_1234);
        op("R4", 0, 2, 8'h44, 0);
        op("R4", 0, 2, 8'h48, 0);
        // R5: size code 3 is rejected
        op("R5", 0, 3, 8'h40, 0);
        op("R5", 1, 3, 8'h40, 32'hDEAD_BEEF);
        op("R5", 0, 2, 8'h40, 0);
        // R6: misaligned accesses are silent, including in the SFR range
        op("R6", 1, 1, 8'h41, 32'h0000_5555);
        op("R6", 1, 2, 8'h42, 32'h6666_6666);
        op("R6", 1, 2, 8'h02, 32'h7777_7777);
        op("R6", 0, 1, 8'h13, 0);
        op("R6", 0, 2, 8'h40, 0);
        // Mixed traffic with occasional window changes
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 16 == 0)
                set_win(($urandom % 4) != 0, $urandom % 4, $urandom % 32);
            else
                op("", ($urandom % 2) == 1, $urandom % 4, $urandom % 256, $urandom);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule